// File: doc/BRIEF.md
# Second-Operand Shifter

This block builds the second source operand of a 32-bit ALU from fields that a decoder has already taken apart. The operand is either an 8-bit immediate rotated right across the word, or a register value. A register value can pass through unchanged or go through one of five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag. The shift amount comes either from an instruction field or from the low byte of a second register. With the operand the block returns the carry that the shift produces, ready for a later flag update.

The result is registered once. A request presented with `in_valid` high on one rising clock edge appears on `operand`, `carry_out` and `out_valid` after that edge. When `in_valid` is low the outputs keep their last values.

Top module: `opnd2_shifter`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow an edge where `in_valid` was high. After an edge where `in_valid` was low, `operand` and `carry_out` keep their previous values.
- R2: After reset, `out_valid`, `operand` and `carry_out` are all zero.
- R3: Form 0 (immediate): `operand` is `imm` zero-extended to 32 bits and rotated right by `rot` (0 to 31). `carry_out` is `carry_in` when `rot` is 0, and bit 31 of `operand` otherwise. For example, 0x12 with a rotate of 8 gives 0x12000000, with 16 gives 0x00120000, and with 24 gives 0x00001200.
- R4: Form 1 (plain register): `operand` equals `rm_val` and `carry_out` equals `carry_in`. The shift fields have no effect.
- R5: Form 2 takes its shift amount from `shamt_imm`, and form 3 takes it from `rs_val[7:0]`. The shift kind codes are 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, and 4 rotate through carry. With an amount of 0, every kind except 4 passes `rm_val` through and sets `carry_out` to `carry_in`.
- R6: Logical left by n (1 to 31): `operand` is `rm_val << n`, and `carry_out` is `rm_val[32-n]`.
- R7: Logical right by n (1 to 31): `operand` is `rm_val >> n`, and `carry_out` is `rm_val[n-1]`.
- R8: Arithmetic right by n (1 to 31) fills the vacated bits with `rm_val[31]`. The signed result equals `rm_val` divided by 2^n and rounded toward minus infinity. `carry_out` is `rm_val[n-1]`.
- R9: Rotate right by n (1 to 31): bits leaving bit 0 enter bit 31, and `carry_out` is bit 31 of `operand`.
- R10: Kind 4 in form 2 or form 3 ignores the amount. `operand` is `{carry_in, rm_val[31:1]}` and `carry_out` is `rm_val[0]`.
- R11: Form 3 uses only `rs_val[7:0]`. Logical left by 32 gives 0 with `carry_out` = `rm_val[0]`. Logical right by 32 gives 0 with `carry_out` = `rm_val[31]`. Either logical shift by more than 32 gives 0 with `carry_out` = 0. Arithmetic right by 32 or more fills every bit with `rm_val[31]`, and `carry_out` equals `rm_val[31]`.
- R12: Form 3 rotate right uses the amount modulo 32. A nonzero amount that is a multiple of 32 leaves `rm_val` unchanged and sets `carry_out` to `rm_val[31]`.
- R13: Shift kind codes 5, 6 and 7 in form 2 or form 3 pass `rm_val` through and set `carry_out` to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| form | input | 2 | Operand form: 0 immediate, 1 register, 2 shift by field, 3 shift by register |
| imm | input | 8 | Unsigned immediate value |
| rot | input | 5 | Right-rotate amount for the immediate |
| shift_type | input | 3 | Shift kind code |
| shamt_imm | input | 5 | Shift amount from the instruction field |
| rm_val | input | 32 | Register value to be shifted |
| rs_val | input | 32 | Register holding the shift amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The only state in the block is the output stage, so any error in the shift or carry logic shows on `operand` or `carry_out` in the cycle that follows the request, and in no other cycle. A stage that fails to hold would show as a changed operand after an idle edge. A stage that fails to clear would show as a nonzero operand or valid flag straight after reset. The bench compares each result against a model that moves one bit per step, so an error in the amount qualifier shows up as a wrong result at the boundary amounts 0, 32, 33 and multiples of 32. Those amounts are all part of the sweep.

// File: rtl/opnd2_pkg.sv
`timescale 1ns/1ps
package opnd2_pkg;

    typedef enum logic [1:0] {
        FORM_IMM = 2'd0,
        FORM_REG = 2'd1,
        FORM_SHI = 2'd2,
        FORM_SHR = 2'd3
    } form_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shkind_e;

    // qualifiers of a shift amount beyond its low bits
    typedef struct packed {
        logic zero;       // whole amount is zero
        logic eq_full;    // amount equals the word width
        logic over_full;  // amount exceeds the word width
    } amt_flags_t;

endpackage

// File: rtl/opnd2_rotr.sv
`timescale 1ns/1ps
module opnd2_rotr #(
    parameter int W = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);

    // logarithmic rotator: stage s rotates by 2**s when amt[s] is set
    logic [W-1:0] stage [0:SH_W];

    assign stage[0] = din;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
                                   : stage[s];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/opnd2_amt_sel.sv
`timescale 1ns/1ps
module opnd2_amt_sel
    import opnd2_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RS_AMT_W = 8,
    localparam int SH_W    = $clog2(DATA_W)
) (
    input  logic                from_reg,
    input  logic [SH_W-1:0]     shamt_imm,
    input  logic [RS_AMT_W-1:0] rs_low,
    output logic [SH_W-1:0]     amt,
    output amt_flags_t          flags
);

    localparam logic [RS_AMT_W-1:0] FULL = RS_AMT_W'(DATA_W);

    always_comb begin
        if (from_reg) begin
            amt             = rs_low[SH_W-1:0];
            flags.zero      = (rs_low == '0);
            flags.eq_full   = (rs_low == FULL);
            flags.over_full = (rs_low > FULL);
        end else begin
            amt             = shamt_imm;
            flags.zero      = (shamt_imm == '0);
            flags.eq_full   = 1'b0;
            flags.over_full = 1'b0;
        end
    end

endmodule

// File: rtl/opnd2_shift_core.sv
`timescale 1ns/1ps
module opnd2_shift_core
    import opnd2_pkg::*;
#(
    parameter int W = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    val,
    input  logic [2:0]      kind,
    input  logic [SH_W-1:0] amt,
    input  amt_flags_t      flags,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);

    // widened by one bit so the last bit shifted out lands in a fixed slot
    logic [W:0]   lsl_w;
    logic [W:0]   lsr_w;
    logic [W:0]   asr_w;
    logic [W-1:0] ror_r;

    assign lsl_w = {1'b0, val} << amt;
    assign lsr_w = {val, 1'b0} >> amt;
    assign asr_w = $signed({val, 1'b0}) >>> amt;

    opnd2_rotr #(.W(W)) u_ror (
        .din  (val),
        .amt  (amt),
        .dout (ror_r)
    );

    always_comb begin
        res  = val;
        cout = cin;
        case (kind)
            SH_LSL: begin
                if (flags.zero) begin
                    res  = val;
                    cout = cin;
                end else if (flags.eq_full) begin
                    res  = '0;
                    cout = val[0];
                end else if (flags.over_full) begin
                    res  = '0;
                    cout = 1'b0;
                end else begin
                    res  = lsl_w[W-1:0];
                    cout = lsl_w[W];
                end
            end
            SH_LSR: begin
                if (flags.zero) begin
                    res  = val;
                    cout = cin;
                end else if (flags.eq_full) begin
                    res  = '0;
                    cout = val[W-1];
                end else if (flags.over_full) begin
                    res  = '0;
                    cout = 1'b0;
                end else begin
                    res  = lsr_w[W:1];
                    cout = lsr_w[0];
                end
            end
            SH_ASR: begin
                if (flags.zero) begin
                    res  = val;
                    cout = cin;
                end else if (flags.eq_full || flags.over_full) begin
                    res  = {W{val[W-1]}};
                    cout = val[W-1];
                end else begin
                    res  = asr_w[W:1];
                    cout = asr_w[0];
                end
            end
            SH_ROR: begin
                if (flags.zero) begin
                    res  = val;
                    cout = cin;
                end else if (amt == '0) begin
                    res  = val;
                    cout = val[W-1];
                end else begin
                    res  = ror_r;
                    cout = ror_r[W-1];
                end
            end
            SH_RRX: begin
                res  = {cin, val[W-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/opnd2_shifter.sv
`timescale 1ns/1ps
module opnd2_shifter
    import opnd2_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8,
    parameter int RS_AMT_W = 8,
    localparam int SH_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        form,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SH_W-1:0]   rot,
    input  logic [2:0]        shift_type,
    input  logic [SH_W-1:0]   shamt_imm,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] operand;
        logic              carry;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] imm_rot;
    logic [SH_W-1:0]   sh_amt;
    amt_flags_t        sh_flags;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic              unused_rs_hi;

    assign imm_ext      = {{(DATA_W-IMM_W){1'b0}}, imm};
    assign unused_rs_hi = ^rs_val[DATA_W-1:RS_AMT_W];

    opnd2_rotr #(.W(DATA_W)) u_imm_rot (
        .din  (imm_ext),
        .amt  (rot),
        .dout (imm_rot)
    );

    opnd2_amt_sel #(
        .DATA_W   (DATA_W),
        .RS_AMT_W (RS_AMT_W)
    ) u_amt (
        .from_reg  (form == FORM_SHR),
        .shamt_imm (shamt_imm),
        .rs_low    (rs_val[RS_AMT_W-1:0]),
        .amt       (sh_amt),
        .flags     (sh_flags)
    );

    opnd2_shift_core #(.W(DATA_W)) u_core (
        .val   (rm_val),
        .kind  (shift_type),
        .amt   (sh_amt),
        .flags (sh_flags),
        .cin   (carry_in),
        .res   (sh_res),
        .cout  (sh_cout)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            case (form)
                FORM_IMM: begin
                    st_d.operand = imm_rot;
                    st_d.carry   = (rot == '0) ? carry_in : imm_rot[DATA_W-1];
                end
                FORM_REG: begin
                    st_d.operand = rm_val;
                    st_d.carry   = carry_in;
                end
                default: begin
                    st_d.operand = sh_res;
                    st_d.carry   = sh_cout;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign operand   = st_q.operand;
    assign carry_out = st_q.carry;

endmodule

// File: rtl/opnd2_shifter_chk.sv
`timescale 1ns/1ps
module opnd2_shifter_chk #(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8,
    parameter int RS_AMT_W = 8,
    localparam int SH_W    = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        form,
    input logic [IMM_W-1:0]  imm,
    input logic [SH_W-1:0]   rot,
    input logic [2:0]        shift_type,
    input logic [SH_W-1:0]   shamt_imm,
    input logic [DATA_W-1:0] rm_val,
    input logic [DATA_W-1:0] rs_val,
    input logic              carry_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] operand,
    input logic              carry_out
);

    localparam logic [RS_AMT_W-1:0] FULL = RS_AMT_W'(DATA_W);

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));

    p_imm_norot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form == 2'd0 && rot == '0) |=>
        (operand == {{(DATA_W-IMM_W){1'b0}}, $past(imm)} && carry_out == $past(carry_in)));

    p_reg_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form == 2'd1) |=>
        (operand == $past(rm_val) && carry_out == $past(carry_in)));

    p_zero_amt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form == 2'd2 && shamt_imm == '0 && shift_type != 3'd4) |=>
        (operand == $past(rm_val) && carry_out == $past(carry_in)));

    p_rrx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form[1] && shift_type == 3'd4) |=>
        (operand == {$past(carry_in), $past(rm_val[DATA_W-1:1])} &&
         carry_out == $past(rm_val[0])));

    p_lsl_big_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form == 2'd3 && shift_type == 3'd0 && rs_val[RS_AMT_W-1:0] > FULL) |=>
        (operand == '0 && !carry_out));

    p_asr_big_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form == 2'd3 && shift_type == 3'd2 && rs_val[RS_AMT_W-1:0] >= FULL) |=>
        (operand == {DATA_W{$past(rm_val[DATA_W-1])}} && carry_out == $past(rm_val[DATA_W-1])));

    p_bad_kind_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form[1] && shift_type > 3'd4) |=>
        (operand == $past(rm_val) && carry_out == $past(carry_in)));

endmodule

bind opnd2_shifter opnd2_shifter_chk #(
    .DATA_W   (DATA_W),
    .IMM_W    (IMM_W),
    .RS_AMT_W (RS_AMT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .form       (form),
    .imm        (imm),
    .rot        (rot),
    .shift_type (shift_type),
    .shamt_imm  (shamt_imm),
    .rm_val     (rm_val),
    .rs_val     (rs_val),
    .carry_in   (carry_in),
    .out_valid  (out_valid),
    .operand    (operand),
    .carry_out  (carry_out)
);

// File: tb/sim_opnd2_shifter.sv
`timescale 1ns/1ps
module sim_opnd2_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  form = '0;
    logic [7:0]  imm = '0;
    logic [4:0]  rot = '0;
    logic [2:0]  shift_type = '0;
    logic [4:0]  shamt_imm = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    opnd2_shifter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .form       (form),
        .imm        (imm),
        .rot        (rot),
        .shift_type (shift_type),
        .shamt_imm  (shamt_imm),
        .rm_val     (rm_val),
        .rs_val     (rs_val),
        .carry_in   (carry_in),
        .out_valid  (out_valid),
        .operand    (operand),
        .carry_out  (carry_out)
    );

    // bit-serial model: each step moves one bit and records the bit that left
    function automatic logic [32:0] model(input logic [1:0] f, input logic [7:0] im,
        input logic [4:0] rt, input logic [2:0] k, input logic [4:0] si,
        input logic [31:0] rm, input logic [31:0] rs, input logic c);
        logic [31:0] v;
        logic co;
        int n;
        co = c;
        if (f == 2'd0) begin
            v = {24'b0, im};
            for (int i = 0; i < int'(rt); i++) begin
                co = v[0];
                v  = {v[0], v[31:1]};
            end
        end else if (f == 2'd1) begin
            v = rm;
        end else begin
            v = rm;
            n = (f == 2'd2) ? int'(si) : int'(rs[7:0]);
            case (k)
                3'd0: for (int i = 0; i < n; i++) begin co = v[31]; v = {v[30:0], 1'b0}; end
                3'd1: for (int i = 0; i < n; i++) begin co = v[0]; v = {1'b0, v[31:1]}; end
                3'd2: for (int i = 0; i < n; i++) begin co = v[0]; v = {v[31], v[31:1]}; end
                3'd3: for (int i = 0; i < n; i++) begin co = v[0]; v = {v[0], v[31:1]}; end
                3'd4: begin co = v[0]; v = {c, v[31:1]}; end
                default: ;
            endcase
        end
        return {co, v};
    endfunction

    function automatic string tag(input logic [1:0] f, input logic [2:0] k, input int n);
        if (f == 2'd0) return "R3";
        if (f == 2'd1) return "R4";
        if (k > 3'd4) return "R13";
        if (k == 3'd4) return "R10";
        if (f == 2'd3 && k == 3'd3 && n >= 32) return "R12";
        if (f == 2'd3 && n >= 32) return "R11";
        if (n == 0) return "R5";
        case (k)
            3'd0: return "R6";
            3'd1: return "R7";
            3'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string req, input logic [31:0] exp_op, input logic exp_c);
        checks++;
        if (out_valid !== 1'b1 || operand !== exp_op || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s: valid=%0b operand=%h carry=%0b expected valid=1 operand=%h carry=%0b",
                     req, out_valid, operand, carry_out, exp_op, exp_c);
        end
    endtask

    task automatic apply(input logic [1:0] f, input logic [7:0] im, input logic [4:0] rt,
        input logic [2:0] k, input logic [4:0] si, input logic [31:0] rm,
        input logic [31:0] rs, input logic c);
        logic [32:0] e;
        @(negedge clk);
        in_valid = 1'b1; form = f; imm = im; rot = rt; shift_type = k;
        shamt_imm = si; rm_val = rm; rs_val = rs; carry_in = c;
        e = model(f, im, rt, k, si, rm, rs, c);
        @(negedge clk);
        compare(tag(f, k, (f == 2'd2) ? int'(si) : int'(rs[7:0])), e[31:0], e[32]);
    endtask

    task automatic apply_exp(input string req, input logic [1:0] f, input logic [7:0] im,
        input logic [4:0] rt, input logic [2:0] k, input logic [4:0] si,
        input logic [31:0] rm, input logic [31:0] rs, input logic c,
        input logic [31:0] exp_op, input logic exp_c);
        @(negedge clk);
        in_valid = 1'b1; form = f; imm = im; rot = rt; shift_type = k;
        shamt_imm = si; rm_val = rm; rs_val = rs; carry_in = c;
        @(negedge clk);
        compare(req, exp_op, exp_c);
    endtask

    logic [31:0] pats [6] = '{32'h0000_0001, 32'h8000_0000, 32'hF0F0_A5C3,
                              32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] hold_op;
        logic        hold_c;
        repeat (3) @(negedge clk);
        // R2: reset state
        checks++;
        if (out_valid !== 1'b0 || operand !== 32'h0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R2: valid=%0b operand=%h carry=%0b expected 0 0 0", out_valid, operand, carry_out);
        end
        rst_n = 1'b1;

        // R3: literal examples
        apply_exp("R3", 2'd0, 8'h12, 5'd8,  3'd0, 5'd0, 32'h0, 32'h0, 1'b1, 32'h1200_0000, 1'b0);
        apply_exp("R3", 2'd0, 8'h12, 5'd16, 3'd0, 5'd0, 32'h0, 32'h0, 1'b1, 32'h0012_0000, 1'b0);
        apply_exp("R3", 2'd0, 8'h12, 5'd24, 3'd0, 5'd0, 32'h0, 32'h0, 1'b0, 32'h0000_1200, 1'b0);
        apply_exp("R3", 2'd0, 8'hFF, 5'd0,  3'd0, 5'd0, 32'h0, 32'h0, 1'b1, 32'h0000_00FF, 1'b1);
        // R8: signed division, -100 >> 2 = -25, -100 >> 3 = -13
        apply_exp("R8", 2'd2, 8'h0, 5'd0, 3'd2, 5'd2, 32'hFFFF_FF9C, 32'h0, 1'b0, 32'hFFFF_FFE7, 1'b0);
        apply_exp("R8", 2'd2, 8'h0, 5'd0, 3'd2, 5'd3, 32'hFFFF_FF9C, 32'h0, 1'b0, 32'hFFFF_FFF3, 1'b1);

        // R3: full immediate sweep
        for (int a = 0; a < 256; a++)
            for (int r = 0; r < 32; r++)
                for (int c = 0; c < 2; c++)
                    apply(2'd0, 8'(a), 5'(r), 3'(r % 8), 5'(a), 32'hA5A5_0000, 32'h0, 1'(c));

        // R4: plain register, shift fields varied
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 8; k++)
                apply(2'd1, 8'h0, 5'(k), 3'(k), 5'(3 * k + 1), pats[p], 32'h0000_0021, 1'(k & 1));

        // R5-R10, R13: amount from instruction field
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 8; k++)
                for (int n = 0; n < 32; n++)
                    for (int c = 0; c < 2; c++)
                        apply(2'd2, 8'h0, 5'd0, 3'(k), 5'(n), pats[p], 32'hFFFF_FFFF, 1'(c));

        // R5-R13: amount from register low byte, upper bits noisy
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 8; k++)
                for (int j = 0; j < 71; j++)
                    for (int c = 0; c < 2; c++) begin
                        int n;
                        n = (j < 67) ? j : (j == 67 ? 96 : (j == 68 ? 128 : (j == 69 ? 200 : 255)));
                        apply(2'd3, 8'h0, 5'd0, 3'(k), 5'd7, pats[p], 32'hDEAD_BE00 | 32'(n), 1'(c));
                    end

        // R1: idle cycle holds the last result and drops valid
        apply(2'd2, 8'h0, 5'd0, 3'd3, 5'd5, 32'h1234_5678, 32'h0, 1'b0);
        hold_op = operand;
        hold_c  = carry_out;
        @(negedge clk);
        in_valid = 1'b0; form = 2'd1; rm_val = 32'hCAFE_F00D; carry_in = ~hold_c;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || operand !== hold_op || carry_out !== hold_c) begin
            errors++;
            $display("FAIL R1: valid=%0b operand=%h carry=%0b expected valid=0 operand=%h carry=%0b",
                     out_valid, operand, carry_out, hold_op, hold_c);
        end
        // R1: valid returns one cycle after a new request
        apply(2'd1, 8'h0, 5'd0, 3'd0, 5'd0, 32'h0BAD_CAFE, 32'h0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || operand !== 32'h0BAD_CAFE) begin
            errors++;
            $display("FAIL R1: valid=%0b operand=%h expected valid=0 operand=0badcafe", out_valid, operand);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule